// File: doc/BRIEF.md
# Decompression Code Buffer Ring Sequencer

This block feeds compressed fields or frames to a decoder from a small circular table of code-buffer descriptors kept in host memory. Each descriptor word carries a status flag and a pointer to a list of fragments. At every field start the sequencer fetches the descriptor of the next ring slot over a one-outstanding memory read port. When that slot holds fresh data, the sequencer walks its fragment list and hands each fragment (start address and word count) to a downstream fetch engine, one fragment at a time. It then writes the descriptor back with the status flag set, which marks the buffer as consumed, and raises a level interrupt.

The host refills consumed slots and gives each one back by clearing its status flag. If the next slot is still marked consumed when a field begins, the sequencer does not stall and does not move on. It replays the fragment list of the most recently accepted buffer, so the decoder shows the previous picture again. If no buffer has been accepted since reset, that field passes with no activity. The status word is fetched again at every field start and is never held in a cache.

Top module: `codebuf_ring_seq`

## Requirements
- R1: After reset, `irq`, `rd_req`, `wr_req` and `frag_req` are all low.
- R2: On a `field_start` pulse while idle, the sequencer reads the descriptor at `TBL_BASE + slot`. Descriptor bit 0 is the status flag (0 = fresh data) and bits [16 +: ADDR_W] hold the fragment list pointer. For a fresh slot, the fragment entries at `list + 0, list + 1, ...` are issued in order on `frag_addr` (entry bits [ADDR_W-1:0]) and `frag_len` (entry bits [16 +: LEN_W]), each request held stable until `frag_done`.
- R3: The fragment walk ends after the entry whose bit 31 (last flag) is set, or after MAX_FRAGS entries, whichever comes first.
- R4: After the last fragment of a fresh buffer, the sequencer writes the descriptor back to the same address with bit 0 set and the other bits unchanged. `irq` rises only in the cycle after `wr_ack`.
- R5: `irq` stays high until an `irq_ack` pulse, which clears it. A set in the same cycle as `irq_ack` wins.
- R6: If the fetched descriptor has bit 0 = 1 and a buffer was accepted earlier, the fragment list of the last accepted buffer is issued again, with no write-back and no interrupt.
- R7: If the fetched descriptor has bit 0 = 1 and no buffer has been accepted since reset, no fragment and no write is issued.
- R8: The slot index advances by one modulo ENTRIES only when a fresh buffer is accepted. A replay leaves it unchanged.
- R9: A `field_start` pulse that arrives while the sequencer is busy is ignored.
- R10: At most one of `rd_req`, `wr_req` and `frag_req` is high at a time, and `rd_addr` stays stable while `rd_req` waits for `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| field_start | input | 1 | Pulse at the start of a field or frame |
| rd_req | output | 1 | Memory read request, held until `rd_valid` |
| rd_addr | output | ADDR_W | Word address of the read |
| rd_valid | input | 1 | Read data returned this cycle |
| rd_data | input | 32 | Read data word |
| wr_req | output | 1 | Status write-back request, held until `wr_ack` |
| wr_addr | output | ADDR_W | Descriptor address being written back |
| wr_data | output | 32 | Descriptor word with status bit set |
| wr_ack | input | 1 | Write accepted |
| frag_req | output | 1 | Fragment transfer request, held until `frag_done` |
| frag_addr | output | ADDR_W | Fragment start address |
| frag_len | output | LEN_W | Fragment length in words |
| frag_done | input | 1 | Fetch engine finished the fragment |
| irq | output | 1 | Level interrupt: a buffer was consumed |
| irq_ack | input | 1 | Write-one-to-clear acknowledge pulse |

## Verification
The bench keeps the default ENTRIES = 4 and MAX_FRAGS = 8 and moves the table to TBL_BASE = 8. With a non-zero base, a slot-offset error lands on the wrong descriptor. With four slots, the ring wraps back to slot 0 within a short run. One fragment list has nine entries and no last flag until the ninth, so the MAX_FRAGS cut-off is exercised. The runs also cover a replay that falls between two accepted buffers, and a slot refilled with a new list pointer, which shows that the status word is fetched again at each field start.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
    localparam int WORD_W   = 32;
    localparam int STAT_BIT = 0;
    localparam int PTR_LSB  = 16;
    localparam int LEN_LSB  = 16;
    localparam int LAST_BIT = 31;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESC,
        ST_FRD,
        ST_XFER,
        ST_WB
    } seq_state_e;
endpackage

// File: rtl/cbr_ring_idx.sv
module cbr_ring_idx #(
    parameter int ENTRIES = 4,
    parameter int IDX_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] idx
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } ring_t;

    ring_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (advance) begin
            if (r_q.idx == IDX_W'(ENTRIES - 1)) begin
                r_d.idx = '0;
            end else begin
                r_d.idx = r_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign idx = r_q.idx;
endmodule

// File: rtl/cbr_replay_reg.sv
module cbr_replay_reg #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] ptr_in,
    output logic              have_buf,
    output logic [ADDR_W-1:0] ptr_out
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] ptr;
    } keep_t;

    keep_t k_d, k_q;

    always_comb begin
        k_d = k_q;
        if (load) begin
            k_d.valid = 1'b1;
            k_d.ptr   = ptr_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k_q <= '0;
        end else begin
            k_q <= k_d;
        end
    end

    assign have_buf = k_q.valid;
    assign ptr_out  = k_q.ptr;
endmodule

// File: rtl/cbr_irq_ctl.sv
module cbr_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic ack,
    output logic irq
);
    typedef struct packed {
        logic pend;
    } irq_t;

    irq_t i_d, i_q;

    always_comb begin
        i_d = i_q;
        if (ack) begin
            i_d.pend = 1'b0;
        end
        if (set) begin
            i_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_q <= '0;
        end else begin
            i_q <= i_d;
        end
    end

    assign irq = i_q.pend;
endmodule

// File: rtl/codebuf_ring_seq.sv
module codebuf_ring_seq
    import cbr_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter int              LEN_W     = 12,
    parameter int              ENTRIES   = 4,
    parameter int              MAX_FRAGS = 8,
    parameter logic [ADDR_W-1:0] TBL_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_start,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [31:0]       rd_data,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data,
    input  logic              wr_ack,
    output logic              frag_req,
    output logic [ADDR_W-1:0] frag_addr,
    output logic [LEN_W-1:0]  frag_len,
    input  logic              frag_done,
    output logic              irq,
    input  logic              irq_ack
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int FC_W  = (MAX_FRAGS > 1) ? $clog2(MAX_FRAGS) : 1;

    typedef struct packed {
        seq_state_e        st;
        logic [FC_W-1:0]   fcnt;
        logic [ADDR_W-1:0] list_ptr;
        logic              fresh;
        logic [IDX_W-1:0]  wb_idx;
        logic [WORD_W-1:0] desc;
        logic [ADDR_W-1:0] f_addr;
        logic [LEN_W-1:0]  f_len;
        logic              f_last;
    } seq_t;

    seq_t s_d, s_q;

    logic              take;
    logic              irq_set;
    logic [IDX_W-1:0]  slot;
    logic              have_buf;
    logic [ADDR_W-1:0] last_ptr;
    logic              end_of_list;

    cbr_ring_idx #(
        .ENTRIES(ENTRIES),
        .IDX_W  (IDX_W)
    ) u_ring (
        .clk    (clk),
        .rst_n  (rst_n),
        .advance(take),
        .idx    (slot)
    );

    cbr_replay_reg #(
        .ADDR_W(ADDR_W)
    ) u_keep (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (take),
        .ptr_in  (rd_data[PTR_LSB +: ADDR_W]),
        .have_buf(have_buf),
        .ptr_out (last_ptr)
    );

    cbr_irq_ctl u_irq (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (irq_set),
        .ack  (irq_ack),
        .irq  (irq)
    );

    assign end_of_list = s_q.f_last || (s_q.fcnt == FC_W'(MAX_FRAGS - 1));

    always_comb begin
        s_d     = s_q;
        rd_req  = 1'b0;
        rd_addr = '0;
        wr_req  = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        take    = 1'b0;
        irq_set = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (field_start) begin
                    s_d.st = ST_DESC;
                end
            end
            ST_DESC: begin
                rd_req  = 1'b1;
                rd_addr = TBL_BASE + ADDR_W'(slot);
                if (rd_valid) begin
                    s_d.fcnt = '0;
                    if (!rd_data[STAT_BIT]) begin
                        take         = 1'b1;
                        s_d.list_ptr = rd_data[PTR_LSB +: ADDR_W];
                        s_d.desc     = rd_data;
                        s_d.wb_idx   = slot;
                        s_d.fresh    = 1'b1;
                        s_d.st       = ST_FRD;
                    end else if (have_buf) begin
                        s_d.list_ptr = last_ptr;
                        s_d.fresh    = 1'b0;
                        s_d.st       = ST_FRD;
                    end else begin
                        s_d.st = ST_IDLE;
                    end
                end
            end
            ST_FRD: begin
                rd_req  = 1'b1;
                rd_addr = s_q.list_ptr + ADDR_W'(s_q.fcnt);
                if (rd_valid) begin
                    s_d.f_addr = rd_data[ADDR_W-1:0];
                    s_d.f_len  = rd_data[LEN_LSB +: LEN_W];
                    s_d.f_last = rd_data[LAST_BIT];
                    s_d.st     = ST_XFER;
                end
            end
            ST_XFER: begin
                if (frag_done) begin
                    if (end_of_list) begin
                        s_d.st = s_q.fresh ? ST_WB : ST_IDLE;
                    end else begin
                        s_d.fcnt = s_q.fcnt + 1'b1;
                        s_d.st   = ST_FRD;
                    end
                end
            end
            ST_WB: begin
                wr_req  = 1'b1;
                wr_addr = TBL_BASE + ADDR_W'(s_q.wb_idx);
                wr_data = s_q.desc | WORD_W'(1);
                if (wr_ack) begin
                    irq_set = 1'b1;
                    s_d.st  = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign frag_req  = (s_q.st == ST_XFER);
    assign frag_addr = s_q.f_addr;
    assign frag_len  = s_q.f_len;
endmodule

// File: rtl/cbr_seq_chk.sv
module cbr_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_valid,
    input logic              wr_req,
    input logic [31:0]       wr_data,
    input logic              wr_ack,
    input logic              frag_req,
    input logic [ADDR_W-1:0] frag_addr,
    input logic [LEN_W-1:0]  frag_len,
    input logic              frag_done,
    input logic              irq,
    input logic              irq_ack
);
    p_one_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_req, wr_req, frag_req}));

    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

    p_frag_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frag_req && !frag_done) |=> (frag_req && $stable(frag_addr) && $stable(frag_len)));

    p_wb_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> wr_data[0]);

    p_irq_after_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(wr_req && wr_ack));

    p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);

    p_irq_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !(wr_req && wr_ack)) |=> !irq);
endmodule

bind codebuf_ring_seq cbr_seq_chk #(
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .rd_valid (rd_valid),
    .wr_req   (wr_req),
    .wr_data  (wr_data),
    .wr_ack   (wr_ack),
    .frag_req (frag_req),
    .frag_addr(frag_addr),
    .frag_len (frag_len),
    .frag_done(frag_done),
    .irq      (irq),
    .irq_ack  (irq_ack)
);

// File: tb/sim_codebuf_ring_seq.sv
`timescale 1ns/1ps
module sim_codebuf_ring_seq;
    localparam int AW = 16;
    localparam int LW = 12;
    localparam logic [15:0] TB = 16'h0008;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic field_start = 1'b0;
    logic rd_req, wr_req, frag_req, irq;
    logic [AW-1:0] rd_addr, wr_addr, frag_addr;
    logic [LW-1:0] frag_len;
    logic [31:0] wr_data;
    logic rd_valid = 1'b0;
    logic [31:0] rd_data = '0;
    logic wr_ack = 1'b0;
    logic frag_done = 1'b0;
    logic irq_ack = 1'b0;

    logic [31:0] mem [0:255];
    int wr_cnt = 0;
    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;
    logic [27:0] sbq [$];

    always #4 clk = ~clk;

    codebuf_ring_seq #(
        .ADDR_W(AW), .LEN_W(LW), .ENTRIES(4), .MAX_FRAGS(8), .TBL_BASE(TB)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .field_start(field_start),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
        .frag_req(frag_req), .frag_addr(frag_addr), .frag_len(frag_len),
        .frag_done(frag_done), .irq(irq), .irq_ack(irq_ack)
    );

    // memory, write port and fetch engine models
    always @(posedge clk) begin
        rd_valid  <= rd_req && !rd_valid;
        rd_data   <= mem[rd_addr[7:0]];
        wr_ack    <= wr_req && !wr_ack;
        frag_done <= frag_req && !frag_done;
        if (wr_req && !wr_ack) begin
            mem[wr_addr[7:0]] <= wr_data;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && frag_req && frag_done) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R9 unexpected fragment", int'({frag_addr, frag_len}), 0);
            end else begin
                logic [27:0] e;
                e = sbq.pop_front();
                chk({frag_addr, frag_len} == e, "R2 fragment order", int'({frag_addr, frag_len}), int'(e));
            end
        end
    end

    function automatic logic [31:0] frag_w(input logic [15:0] a, input logic [11:0] n, input bit last);
        return {last, 3'b000, n, a};
    endfunction

    function automatic logic [31:0] desc_w(input logic [15:0] ptr, input bit stat);
        return {ptr, 15'd0, stat};
    endfunction

    // driver: expected fragments of a list, cut at last flag or 8 entries
    task automatic push_list(input int base);
        for (int i = 0; i < 8; i++) begin
            sbq.push_back({mem[base + i][15:0], mem[base + i][27:16]});
            if (mem[base + i][31]) break;
        end
    endtask

    task automatic pulse_field();
        @(negedge clk); field_start = 1'b1;
        @(negedge clk); field_start = 1'b0;
    endtask

    task automatic run_field();
        pulse_field();
        repeat (150) @(negedge clk);
    endtask

    task automatic ack_irq();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic give(input int slot, input logic [15:0] ptr);
        mem[int'(TB) + slot] = desc_w(ptr, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int w0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        mem[int'(TB) + 0] = desc_w(16'h0020, 1'b1);
        mem[int'(TB) + 1] = desc_w(16'h0040, 1'b1);
        mem[int'(TB) + 2] = desc_w(16'h0060, 1'b1);
        mem[int'(TB) + 3] = desc_w(16'h0080, 1'b1);
        mem[8'h20] = frag_w(16'h1000, 12'd5, 0);
        mem[8'h21] = frag_w(16'h1100, 12'd7, 0);
        mem[8'h22] = frag_w(16'h1200, 12'd9, 1);
        for (int i = 0; i < 9; i++) mem[8'h40 + i] = frag_w(16'h2000 + 16'(i), 12'(i + 1), i == 8);
        mem[8'h60] = frag_w(16'h3000, 12'd1, 1);
        mem[8'h80] = frag_w(16'h4000, 12'd2, 0);
        mem[8'h81] = frag_w(16'h4100, 12'd3, 1);
        mem[8'hA0] = frag_w(16'h5000, 12'd4, 0);
        mem[8'hA1] = frag_w(16'h5100, 12'd6, 1);

        repeat (4) @(negedge clk);
        chk({irq, rd_req, wr_req, frag_req} == 4'b0, "R1 reset outputs",
            int'({irq, rd_req, wr_req, frag_req}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({irq, rd_req, wr_req, frag_req} == 4'b0, "R1 idle after reset",
            int'({irq, rd_req, wr_req, frag_req}), 0);

        // R7: nothing ever available
        run_field();
        chk(wr_cnt == 0, "R7 no write when empty", wr_cnt, 0);
        chk(irq == 1'b0, "R7 no irq when empty", int'(irq), 0);

        // R2/R4: fresh slot 0
        give(0, 16'h0020);
        push_list(16'h20);
        run_field();
        chk(sbq.size() == 0, "R2 all fragments issued", sbq.size(), 0);
        chk(mem[int'(TB)] == desc_w(16'h0020, 1'b1), "R4 write-back word", int'(mem[int'(TB)]),
            int'(desc_w(16'h0020, 1'b1)));
        chk(irq == 1'b1, "R4 irq raised", int'(irq), 1);

        // R5: level hold then clear
        repeat (20) @(negedge clk);
        chk(irq == 1'b1, "R5 irq held", int'(irq), 1);
        ack_irq();
        chk(irq == 1'b0, "R5 irq cleared by ack", int'(irq), 0);

        // R6: slot 1 not ready -> replay slot 0 list
        w0 = wr_cnt;
        push_list(16'h20);
        run_field();
        chk(sbq.size() == 0, "R6 replay fragments", sbq.size(), 0);
        chk(wr_cnt == w0, "R6 no write-back on replay", wr_cnt, w0);
        chk(irq == 1'b0, "R6 no irq on replay", int'(irq), 0);

        // R3/R8: slot 1 (index not moved by replay), 9-entry list cut at 8
        give(1, 16'h0040);
        push_list(16'h40);
        run_field();
        chk(sbq.size() == 0, "R3 cut at eight fragments", sbq.size(), 0);
        chk(mem[int'(TB) + 1][0] == 1'b1, "R8 slot 1 consumed after replay", int'(mem[int'(TB) + 1][0]), 1);
        ack_irq();

        // R8: slots 2, 3, then wrap to refilled slot 0 with new list
        give(2, 16'h0060);
        give(3, 16'h0080);
        push_list(16'h60);
        run_field();
        push_list(16'h80);
        run_field();
        chk(mem[int'(TB) + 3][0] == 1'b1, "R8 slot 3 consumed", int'(mem[int'(TB) + 3][0]), 1);
        give(0, 16'h00A0);
        push_list(16'hA0);
        run_field();
        chk(sbq.size() == 0, "R8 wrap to slot 0 new list", sbq.size(), 0);
        chk(mem[int'(TB)] == desc_w(16'h00A0, 1'b1), "R8 wrap write-back", int'(mem[int'(TB)]),
            int'(desc_w(16'h00A0, 1'b1)));
        ack_irq();

        // R9: second field_start while busy is ignored
        give(1, 16'h0040);
        give(2, 16'h0060);
        push_list(16'h40);
        pulse_field();
        repeat (10) @(negedge clk);
        field_start = 1'b1;
        @(negedge clk); field_start = 1'b0;
        repeat (150) @(negedge clk);
        chk(mem[int'(TB) + 2][0] == 1'b0, "R9 slot 2 untouched", int'(mem[int'(TB) + 2][0]), 0);
        chk(sbq.size() == 0, "R9 busy run complete", sbq.size(), 0);
        push_list(16'h60);
        run_field();
        chk(mem[int'(TB) + 2][0] == 1'b1, "R9 slot 2 taken next field", int'(mem[int'(TB) + 2][0]), 1);
        chk(sbq.size() == 0, "R10 request flow complete", sbq.size(), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule